// File: doc/BRIEF.md
# Dual-Line Continuous-Read Flash Responder

This block plays the memory device in a two-data-line serial flash read. It oversamples chip select, the serial clock and both data lines in the system clock domain, decodes the incoming transaction and answers with bytes from a small store. The store is filled by reset logic. The block is meant as a companion model next to a host-side serial flash controller. It responds like a device that understands one command: the fast read on two data lines.

A transaction normally starts with an 8-bit opcode on data line 0. The 24-bit address follows two bits per clock, then a 4-bit mode nibble, then two turnaround clocks during which nobody drives the lines. After that the responder streams data two bits per clock. The mode nibble can arm continuous read. When armed, the next transaction skips the opcode and begins directly with the address. Another mode value disarms it again.

The block exposes the output value and an output-enable separately, so a pad or a bench can form the tristate bus.

Top module: `dio_flash_resp`

## Requirements
- R1: After reset, `dq_oe` is low and continuous read is disarmed, so the first transaction must begin with an opcode. A reset also disarms a previously armed state.
- R2: While disarmed, the first 8 clocks after chip select falls carry an opcode on `dq_in[0]`, most significant bit first. Only 8'hBB starts a read. Any other opcode leaves the outputs undriven until chip select rises and leaves the armed state as it was.
- R3: The address phase lasts 14 clocks at two bits per clock, with `dq_in[1]` the more significant bit of each pair. It carries the 24-bit address most significant bit first, then the mode nibble M[7:4].
- R4: If the mode nibble has M[5:4] = 2'b10, continuous read is armed and the next transaction starts at its address phase with no opcode.
- R5: Any other value of M[5:4], including a nibble of 4'b0000, disarms continuous read. M[7:6] has no effect on this decision.
- R6: During the two clocks after the mode nibble, `dq_oe` stays low.
- R7: Data starts on the falling clock edge after the second turnaround clock. It gives the addressed byte, most significant pair first, with `dq_out[1]` carrying the higher bit. Each following byte comes from the next address. The store index is the low MEM_AW address bits and wraps.
- R8: After reset, the byte at store index i is (29*i + 195) mod 256.
- R9: `dq_oe` is low whenever chip select is high and through every opcode, address and mode clock.
- R10: If chip select rises before the last address-phase clock, the armed state stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cs_n | input | 1 | Chip select from the host, active low |
| sck | input | 1 | Serial clock from the host; inputs are sampled on its rising edge |
| dq_in | input | 2 | Data lines as seen from the host |
| dq_out | output | 2 | Data the responder places on the lines |
| dq_oe | output | 1 | High when the responder drives both lines |

## Verification
A table of transactions walks through opcode-led reads, address-only reads while armed, a foreign opcode, and mode nibbles that arm, keep armed with the reserved bits set, disarm with zero, and disarm with M[5:4] = 01. If the responder misreads the armed state, it takes the opcode as address bits or the address as an opcode, so the returned bytes separate a correct latch from a stale one. Addresses at the top of the store show the index wrap, and a high address shows that only the low bits select the byte. Directed cases cover an aborted address phase, which must keep the armed state, and a reset while armed.

// File: rtl/dio_resp_pkg.sv
package dio_resp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INSTR,
    PH_ADDR,
    PH_TURN,
    PH_DATA,
    PH_SINK
  } phase_e;

  localparam logic [7:0] READ_DUAL_OP = 8'hBB;
  localparam int         ADDR_BITS    = 24;
  localparam int         MODE_BITS    = 4;
  localparam int         TURN_CLKS    = 2;
  localparam int         OP_BITS      = 8;

  // Preload pattern of the byte store.
  function automatic logic [7:0] seed_byte(input int unsigned idx);
    return 8'((idx * 29) + 195);
  endfunction

endpackage

// File: rtl/dio_resp_sync.sv
module dio_resp_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic [1:0] dq_i,
  output logic       sel_o,
  output logic       rise_o,
  output logic       fall_o,
  output logic [1:0] dq_o
);

  localparam int VW = 4;
  localparam int CW = VW * STAGES;
  localparam logic [VW-1:0] IDLE_VEC = 4'b1000;

  logic [CW-1:0] chain_q, chain_d;
  logic [VW-1:0] tail;
  logic          sck_prev_q;

  always_comb begin
    chain_d = {chain_q[CW-VW-1:0], cs_n_i, sck_i, dq_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= {STAGES{IDLE_VEC}};
      sck_prev_q <= 1'b0;
    end else begin
      chain_q    <= chain_d;
      sck_prev_q <= tail[2];
    end
  end

  assign tail   = chain_q[CW-1 -: VW];
  assign sel_o  = ~tail[3];
  assign rise_o = tail[2] & ~sck_prev_q;
  assign fall_o = ~tail[2] & sck_prev_q;
  assign dq_o   = tail[1:0];

endmodule

// File: rtl/dio_resp_store.sv
module dio_resp_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  import dio_resp_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cells_q[g] <= seed_byte(g);
        end else begin
          cells_q[g] <= cells_q[g];
        end
      end
    end
  endgenerate

  assign rd_byte = cells_q[rd_idx];

endmodule

// File: rtl/dio_resp_seq.sv
module dio_resp_seq
  import dio_resp_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rise,
  input  logic             fall,
  input  logic [1:0]       dq,
  input  logic [7:0]       rd_byte,
  output logic [PTR_W-1:0] ptr,
  output logic [1:0]       dq_out,
  output logic             dq_oe,
  output phase_e           phase,
  output logic             cont
);

  localparam int ADDR_CLKS  = (ADDR_BITS + MODE_BITS) / 2;
  localparam int SHIFT_CLKS = ADDR_BITS / 2;
  localparam int CNT_W      = $clog2((ADDR_CLKS > OP_BITS) ? ADDR_CLKS : OP_BITS);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [6:0]       ins_q, ins_d;
  logic [PTR_W-1:0] shf_q, shf_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [1:0]       pair_q, pair_d;
  logic             cont_q, cont_d;
  logic [1:0]       out_q, out_d;
  logic             oe_q, oe_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    ins_d   = ins_q;
    shf_d   = shf_q;
    ptr_d   = ptr_q;
    pair_d  = pair_q;
    cont_d  = cont_q;
    out_d   = out_q;
    oe_d    = oe_q;

    unique case (phase_q)
      PH_IDLE: begin
        oe_d = 1'b0;
        if (sel) begin
          phase_d = cont_q ? PH_ADDR : PH_INSTR;
          cnt_d   = '0;
        end
      end
      PH_INSTR: begin
        if (rise) begin
          ins_d = {ins_q[5:0], dq[0]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OP_BITS - 1)) begin
            phase_d = ({ins_q, dq[0]} == READ_DUAL_OP) ? PH_ADDR : PH_SINK;
            cnt_d   = '0;
          end
        end
      end
      PH_ADDR: begin
        if (rise) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q < CNT_W'(SHIFT_CLKS)) begin
            shf_d = (PTR_W > 2) ? {shf_q[PTR_W-3:0], dq} : PTR_W'(dq);
          end
          if (cnt_q == CNT_W'(ADDR_CLKS - 1)) begin
            // this last pair is M[5:4]; the pair before it (M[7:6]) is not kept
            ptr_d   = shf_q;
            cont_d  = (dq == 2'b10);
            phase_d = PH_TURN;
            cnt_d   = '0;
          end
        end
      end
      PH_TURN: begin
        if (rise) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(TURN_CLKS - 1)) begin
            phase_d = PH_DATA;
            pair_d  = '0;
          end
        end
      end
      PH_DATA: begin
        if (fall) begin
          out_d  = rd_byte[{~pair_q, 1'b1} -: 2];
          oe_d   = 1'b1;
          pair_d = pair_q + 1'b1;
          if (pair_q == 2'd3) begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      default: begin
        oe_d = 1'b0;
      end
    endcase

    if (!sel) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ins_q   <= '0;
      shf_q   <= '0;
      ptr_q   <= '0;
      pair_q  <= '0;
      cont_q  <= 1'b0;
      out_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ins_q   <= ins_d;
      shf_q   <= shf_d;
      ptr_q   <= ptr_d;
      pair_q  <= pair_d;
      cont_q  <= cont_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
    end
  end

  assign ptr    = ptr_q;
  assign dq_out = out_q;
  assign dq_oe  = oe_q;
  assign phase  = phase_q;
  assign cont   = cont_q;

endmodule

// File: rtl/dio_flash_resp.sv
module dio_flash_resp #(
  parameter int SYNC_STAGES = 2,
  parameter int MEM_AW      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [1:0] dq_in,
  output logic [1:0] dq_out,
  output logic       dq_oe
);
  import dio_resp_pkg::*;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              sel, rise, fall;
  logic [1:0]        dq_s;
  logic [MEM_AW-1:0] ptr;
  logic [7:0]        rd_byte;
  phase_e            phase_w;
  logic              cont_w;

  // reset asserts at once and leaves two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  dio_resp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cs_n_i (cs_n),
    .sck_i  (sck),
    .dq_i   (dq_in),
    .sel_o  (sel),
    .rise_o (rise),
    .fall_o (fall),
    .dq_o   (dq_s)
  );

  dio_resp_seq #(.PTR_W(MEM_AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel),
    .rise    (rise),
    .fall    (fall),
    .dq      (dq_s),
    .rd_byte (rd_byte),
    .ptr     (ptr),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .phase   (phase_w),
    .cont    (cont_w)
  );

  dio_resp_store #(.AW(MEM_AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (ptr),
    .rd_byte (rd_byte)
  );

endmodule

// File: rtl/dio_flash_resp_chk.sv
module dio_flash_resp_chk
  import dio_resp_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   sel,
  input logic   rise,
  input logic   fall,
  input phase_e phase,
  input logic   cont,
  input logic   dq_oe
);

  assert_oe_in_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (phase == PH_DATA));

  assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (phase == PH_IDLE) && !dq_oe);

  assert_turn_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> !dq_oe);

  assert_cont_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cont) |-> $past(phase == PH_ADDR && rise));

  assert_entry_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && sel) |=> (phase == ($past(cont) ? PH_ADDR : PH_INSTR)));

  assert_drive_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(fall));

endmodule

bind dio_flash_resp dio_flash_resp_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .sel   (sel),
  .rise  (rise),
  .fall  (fall),
  .phase (phase_w),
  .cont  (cont_w),
  .dq_oe (dq_oe)
);

// File: tb/sim_dio_flash_resp.sv
module sim_dio_flash_resp;

  localparam int H   = 6;   // system clocks per serial half period
  localparam int AWB = 6;   // store index bits used by the design default

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       sck;
  logic [1:0] dq_in;
  logic [1:0] dq_out;
  logic       dq_oe;

  always #4 clk = ~clk;

  dio_flash_resp u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;
  logic [1:0] smp_q;
  logic       smp_oe;
  int         in_oe_n, turn_oe_n, data_oe_n;
  logic       idle_oe;
  logic [7:0] got [4];
  bit         exp_cont;

  // R8 pattern
  function automatic logic [7:0] exp_byte(input int unsigned a);
    return 8'((((a % (1 << AWB)) * 29) + 195) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] d);
    dq_in = d;
    repeat (H) @(negedge clk);
    smp_q  = dq_out;
    smp_oe = dq_oe;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input bit send_op, input logic [7:0] op, input logic [23:0] addr,
                      input logic [3:0] nib, input int nbytes);
    logic [27:0] w;
    w = {addr, nib};
    in_oe_n = 0; turn_oe_n = 0; data_oe_n = 0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    if (send_op) begin
      for (int i = 7; i >= 0; i--) begin
        tick({1'b0, op[i]});
        in_oe_n += int'(smp_oe);
      end
    end
    for (int k = 13; k >= 0; k--) begin
      tick(w[2*k+1 -: 2]);
      in_oe_n += int'(smp_oe);
    end
    for (int t = 0; t < 2; t++) begin
      tick(2'b00);
      turn_oe_n += int'(smp_oe);
    end
    for (int b = 0; b < nbytes; b++) begin
      got[b] = 8'h00;
      for (int p = 0; p < 4; p++) begin
        tick(2'b00);
        got[b] = {got[b][5:0], smp_q};
        data_oe_n += int'(smp_oe);
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H + 4) @(negedge clk);
    idle_oe = dq_oe;
  endtask

  // {opcode, address, mode nibble M[7:4]}
  localparam logic [35:0] VEC [8] = '{
    {8'hBB, 24'h000010, 4'b0000},  // plain read, stays disarmed
    {8'hBB, 24'h000005, 4'b0010},  // arms
    {8'h00, 24'h00003E, 4'b1110},  // address only, reserved bits set, stays armed, wraps
    {8'h00, 24'h123456, 4'b0000},  // address only, nibble zero disarms
    {8'h03, 24'h000020, 4'b0010},  // foreign opcode, ignored
    {8'hBB, 24'hFFFFFF, 4'b0110},  // arms, wraps from top
    {8'h00, 24'h000001, 4'b0001},  // address only, M[5:4]=01 disarms
    {8'hBB, 24'h000020, 4'b0000}   // opcode again after disarm
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  op;
    logic [23:0] ad;
    logic [3:0]  nb;
    bit          reads;

    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; dq_in = 2'b00;
    repeat (5) @(negedge clk);
    // R1: outputs quiet in and after reset
    check(dq_oe == 1'b0, "R1 oe in reset", int'(dq_oe), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(dq_oe == 1'b0, "R1 oe after reset", int'(dq_oe), 0);
    exp_cont = 1'b0;

    for (int v = 0; v < 8; v++) begin
      {op, ad, nb} = VEC[v];
      reads = exp_cont || (op == 8'hBB);
      xfer(!exp_cont, op, ad, nb, 3);
      check(in_oe_n == 0, "R9 no drive in input phases", in_oe_n, 0);
      check(turn_oe_n == 0, "R6 no drive in turnaround", turn_oe_n, 0);
      check(idle_oe == 1'b0, "R9 no drive after deselect", int'(idle_oe), 0);
      if (reads) begin
        check(data_oe_n == 12, "R7 drive through data", data_oe_n, 12);
        for (int b = 0; b < 3; b++) begin
          // R2 R3 R4 R5 R7 R8: byte at address+b from the preload pattern
          check(got[b] == exp_byte(int'(ad) + b), "R2 R3 R4 R5 R7 R8 data byte",
                int'(got[b]), int'(exp_byte(int'(ad) + b)));
        end
        exp_cont = (nb[1:0] == 2'b10);
      end else begin
        check(data_oe_n == 0, "R2 foreign opcode not answered", data_oe_n, 0);
      end
    end

    // R10: arm, abort inside the address phase, then an address-only read must work
    xfer(1'b1, 8'hBB, 24'h000008, 4'b0010, 1);
    check(got[0] == exp_byte(8), "R4 arming read", int'(got[0]), int'(exp_byte(8)));
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < 6; k++) tick(2'b00);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H + 4) @(negedge clk);
    check(dq_oe == 1'b0, "R9 quiet after abort", int'(dq_oe), 0);
    xfer(1'b0, 8'h00, 24'h00000C, 4'b0010, 2);
    check(got[0] == exp_byte(12), "R10 armed state kept over abort", int'(got[0]), int'(exp_byte(12)));
    check(got[1] == exp_byte(13), "R10 armed state kept over abort", int'(got[1]), int'(exp_byte(13)));

    // R1: reset while armed disarms; an opcode-led read must then work
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    xfer(1'b1, 8'hBB, 24'h000003, 4'b0000, 2);
    check(got[0] == exp_byte(3), "R1 disarmed after reset", int'(got[0]), int'(exp_byte(3)));
    check(got[1] == exp_byte(4), "R1 disarmed after reset", int'(got[1]), int'(exp_byte(4)));

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule